// File: doc/BRIEF.md
# Mailbox Interrupt Request and Vector Unit

This block links an on-chip DSP to an external host processor. When the DSP posts a mailbox command, the block sets a busy flag. That flag drives the host interrupt request line unless the host has set a mask bit. The host clears the flag in one of two ways: it reads the posted command, or it writes a one to a clear bit.

The host answers the interrupt with an active-low acknowledge strobe. The block then places a programmable interrupt vector on the shared data bus and raises the bus output-enable for exactly as long as the block is in its vector-drive phase. A control-register bit selects the acknowledge protocol. In single-pulse protocol, every acknowledge pulse fetches the vector. In double-pulse protocol, the first pulse only arms the sequence and the second pulse fetches the vector.

Because the acknowledge strobe arrives asynchronously, it passes through a synchronizer before the block detects its edges.

Top module: `mbox_irq_vec`

## Requirements
- R1: After reset the interrupt request is low, the bus output-enable is low, the drive data is zero, the busy flag is clear, and the control and vector registers read zero.
- R2: A DSP command write sets the busy flag on the next clock edge. With the mask bit clear, the interrupt request is high from the following cycle onward.
- R3: Control bit 0 is the mask. When it is set, the interrupt request is forced low but the busy flag is kept (status register, address 3, bit 0, still reads 1). Clearing the mask brings the request back.
- R4: A host read strobe at address 2 returns the last DSP command word and clears the busy flag on that clock edge.
- R5: A host write at address 0 with bit 2 set clears the busy flag. Bit 2 is not stored and reads back as 0.
- R6: When a DSP command write and either clear source fall in the same cycle, the busy flag ends up set.
- R7: With control bit 1 = 0 (single-pulse protocol), the output-enable goes high with the vector on the bus data. This happens two clock edges after the acknowledge input falls, and the output-enable goes low two edges after the input rises.
- R8: With control bit 1 = 1 (double-pulse protocol), the first acknowledge pulse leaves the output-enable low. The second pulse drives the vector with the same latency as R7.
- R9: Any host write that changes control bit 1 returns the double-pulse sequencer to idle. The next pulse then counts as a first pulse.
- R10: The vector register (address 1) is host writable and reads back. Whenever the output-enable is low, the bus data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_cmd_wr | input | 1 | DSP command write strobe |
| dsp_cmd_wdata | input | CMD_W | DSP command word |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (read side effects) |
| host_addr | input | 2 | Host register address: 0 control, 1 vector, 2 command, 3 status |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for host_addr |
| iack_n | input | 1 | Asynchronous active-low interrupt acknowledge |
| irq | output | 1 | Interrupt request, active high |
| bus_dout | output | DATA_W | Vector data toward the shared bus |
| bus_oe | output | 1 | Bus output-enable during the vector-drive phase |

## Verification
The bench targets a clear that collides with a DSP write in the same cycle. A design that let the clear win would drop a posted command and leave the interrupt low.

It checks the mask against the busy flag. A design that cleared the flag on masking would lose the request when the host later unmasks.

In double-pulse protocol, the bench confirms that the first pulse leaves the bus tristated. A design that drove on every pulse would collide with other bus drivers.

It also toggles the protocol bit between two pulses. A sequencer that kept its armed state would then drive on the first pulse. Finally, the bench samples the output-enable on each cycle around the synchronizer delay, which catches an extra or missing stage.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FIRST = 2'd1,
      SEQ_ARMED = 2'd2,
      SEQ_DRIVE = 2'd3
   } seq_state_e;

   typedef enum logic {
      ACK_SINGLE = 1'b0,
      ACK_DOUBLE = 1'b1
   } ack_mode_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_VEC  = 2'd1;
   localparam logic [1:0] REG_CMD  = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int CTRL_MASK_BIT = 0;
   localparam int CTRL_MODE_BIT = 1;
   localparam int CTRL_CLR_BIT  = 2;
endpackage

// File: rtl/mbox_ack_sync.sv
module mbox_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_async,
   output logic ack_low,
   output logic ack_fall,
   output logic ack_rise
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] stg_q;
   logic              prev_q;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= 1'b1;
            else        stg_q[0] <= ack_n_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[gi] <= 1'b1;
            else        stg_q[gi] <= stg_q[gi-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= stg_q[LAST];
   end

   assign ack_low  = ~stg_q[LAST];
   assign ack_fall = prev_q & ~stg_q[LAST];
   assign ack_rise = ~prev_q & stg_q[LAST];
endmodule

// File: rtl/mbox_busy_flag.sv
module mbox_busy_flag #(
   parameter int CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             clr,
   output logic [CMD_W-1:0] cmd_q,
   output logic             busy_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         if (cmd_wr) begin
            cmd_q  <= cmd_wdata;
            busy_q <= 1'b1;
         end else if (clr) begin
            busy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mbox_ack_seq.sv
module mbox_ack_seq
   import mbox_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ack_mode_e mode,
   input  logic      restart,
   input  logic      ack_low,
   input  logic      ack_fall,
   input  logic      ack_rise,
   output logic      drive,
   output logic      armed
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (restart) begin
         state_d = SEQ_IDLE;
      end else if (mode == ACK_DOUBLE) begin
         unique case (state_q)
            SEQ_IDLE:  if (ack_fall) state_d = SEQ_FIRST;
            SEQ_FIRST: if (ack_rise) state_d = SEQ_ARMED;
            SEQ_ARMED: if (ack_fall) state_d = SEQ_DRIVE;
            SEQ_DRIVE: if (ack_rise) state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      if (mode == ACK_SINGLE)
         drive = ack_low;
      else
         drive = ((state_q == SEQ_ARMED) && ack_fall) ||
                 ((state_q == SEQ_DRIVE) && ack_low);
   end

   assign armed = (state_q == SEQ_ARMED);
endmodule

// File: rtl/mbox_irq_vec.sv
module mbox_irq_vec
   import mbox_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int VEC_W       = 8,
   parameter int CMD_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dsp_cmd_wr,
   input  logic [CMD_W-1:0]  dsp_cmd_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              iack_n,
   output logic              irq,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe
);
   localparam int CTRL_BITS = CTRL_CLR_BIT + 1;

   initial begin
      if (SYNC_STAGES < 2)      $fatal(1, "SYNC_STAGES must be at least 2");
      if (VEC_W > DATA_W)       $fatal(1, "VEC_W must not exceed DATA_W");
      if (CMD_W > DATA_W)       $fatal(1, "CMD_W must not exceed DATA_W");
      if (DATA_W < CTRL_BITS)   $fatal(1, "DATA_W too narrow for control bits");
   end

   logic             mask_q;
   ack_mode_e        mode_q;
   logic [VEC_W-1:0] vec_q;
   logic [CMD_W-1:0] cmd_q;
   logic             busy_q;
   logic             ctrl_wr, vec_wr, clr, mode_chg;
   logic             ack_low, ack_fall, ack_rise;
   logic             drive, armed;

   assign ctrl_wr  = host_wr && (host_addr == REG_CTRL);
   assign vec_wr   = host_wr && (host_addr == REG_VEC);
   assign clr      = (ctrl_wr && host_wdata[CTRL_CLR_BIT]) ||
                     (host_rd && (host_addr == REG_CMD));
   assign mode_chg = ctrl_wr && (host_wdata[CTRL_MODE_BIT] != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
         mode_q <= ACK_SINGLE;
         vec_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            mask_q <= host_wdata[CTRL_MASK_BIT];
            mode_q <= ack_mode_e'(host_wdata[CTRL_MODE_BIT]);
         end
         if (vec_wr) vec_q <= host_wdata[VEC_W-1:0];
      end
   end

   mbox_busy_flag #(.CMD_W(CMD_W)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (dsp_cmd_wr),
      .cmd_wdata (dsp_cmd_wdata),
      .clr       (clr),
      .cmd_q     (cmd_q),
      .busy_q    (busy_q)
   );

   mbox_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_n_async (iack_n),
      .ack_low     (ack_low),
      .ack_fall    (ack_fall),
      .ack_rise    (ack_rise)
   );

   mbox_ack_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .restart  (mode_chg),
      .ack_low  (ack_low),
      .ack_fall (ack_fall),
      .ack_rise (ack_rise),
      .drive    (drive),
      .armed    (armed)
   );

   assign irq = busy_q & ~mask_q;

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         REG_CTRL: begin
            host_rdata[CTRL_MASK_BIT] = mask_q;
            host_rdata[CTRL_MODE_BIT] = mode_q;
         end
         REG_VEC:  host_rdata[VEC_W-1:0] = vec_q;
         REG_CMD:  host_rdata[CMD_W-1:0] = cmd_q;
         default:  host_rdata[0] = busy_q;
      endcase
   end

   always_comb begin
      bus_dout = '0;
      if (drive) bus_dout[VEC_W-1:0] = vec_q;
   end
   assign bus_oe = drive;
endmodule

// File: rtl/mbox_irq_vec_chk.sv
module mbox_irq_vec_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       dsp_cmd_wr,
   input logic       host_wr,
   input logic       host_rd,
   input logic [1:0] host_addr,
   input logic       iack_n,
   input logic       irq,
   input logic       bus_oe,
   input logic       mask_q,
   input logic       mode_q,
   input logic       busy_q,
   input logic       clr,
   input logic       armed,
   input logic       mode_chg
);
   AST_CMD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_cmd_wr && !(host_wr && host_addr == 2'd0)) |=> (busy_q && irq == !mask_q)); // R2

   AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq); // R3

   AST_CMD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 2'd2 && !dsp_cmd_wr) |=> !busy_q); // R4

   AST_WRITE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && dsp_cmd_wr) |=> busy_q); // R6

   if (SYNC_STAGES == 2) begin : g_lat
      AST_DRIVE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         bus_oe |-> !$past(iack_n, 2)); // R7
   end

   AST_SECOND_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && $rose(bus_oe)) |-> armed); // R8

   AST_MODE_CHANGE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !armed); // R9
endmodule

bind mbox_irq_vec mbox_irq_vec_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dsp_cmd_wr (dsp_cmd_wr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .iack_n     (iack_n),
   .irq        (irq),
   .bus_oe     (bus_oe),
   .mask_q     (mask_q),
   .mode_q     (mode_q),
   .busy_q     (busy_q),
   .clr        (clr),
   .armed      (armed),
   .mode_chg   (mode_chg)
);

// File: tb/tb_mbox_irq_vec.sv
`timescale 1ns/1ps
module tb_mbox_irq_vec;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dsp_cmd_wr = 1'b0;
   logic [7:0]    dsp_cmd_wdata = '0;
   logic          host_wr = 1'b0;
   logic          host_rd = 1'b0;
   logic [1:0]    host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          iack_n = 1'b1;
   logic          irq;
   logic [DW-1:0] bus_dout;
   logic          bus_oe;

   always #2.5 clk = ~clk;

   mbox_irq_vec dut (
      .clk(clk), .rst_n(rst_n),
      .dsp_cmd_wr(dsp_cmd_wr), .dsp_cmd_wdata(dsp_cmd_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .iack_n(iack_n), .irq(irq), .bus_dout(bus_dout), .bus_oe(bus_oe)
   );

   typedef struct {
      string     tag;
      int        kind;   // 0 irq, 1 bus, 2 read data
      logic      oe;
      logic [7:0] val;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   // monitor: compares once outputs have settled after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            case (e.kind)
               0: if (irq !== e.val[0]) begin
                     failures++;
                     $display("FAIL %s irq act=%b exp=%b", e.tag, irq, e.val[0]);
                  end
               1: if (bus_oe !== e.oe || bus_dout !== e.val) begin
                     failures++;
                     $display("FAIL %s bus act=%b/%h exp=%b/%h", e.tag, bus_oe, bus_dout, e.oe, e.val);
                  end
               default: if (host_rdata !== e.val) begin
                     failures++;
                     $display("FAIL %s rdata act=%h exp=%h", e.tag, host_rdata, e.val);
                  end
            endcase
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic exp_irq(string tag, logic v);
      exp_t e;
      e.tag = tag; e.kind = 0; e.oe = 1'b0; e.val = {7'd0, v};
      exp_q.push_back(e);
   endtask

   task automatic exp_bus(string tag, logic oe, logic [7:0] d);
      exp_t e;
      e.tag = tag; e.kind = 1; e.oe = oe; e.val = d;
      exp_q.push_back(e);
   endtask

   task automatic peek(string tag, logic [1:0] a, logic [7:0] v);
      exp_t e;
      host_addr = a;
      e.tag = tag; e.kind = 2; e.oe = 1'b0; e.val = v;
      exp_q.push_back(e);
      tick();
   endtask

   task automatic host_write(logic [1:0] a, logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      tick();
      host_wr = 1'b0;
   endtask

   task automatic dsp_write(logic [7:0] d);
      dsp_cmd_wr = 1'b1; dsp_cmd_wdata = d;
      tick();
      dsp_cmd_wr = 1'b0;
   endtask

   // one acknowledge pulse, output-enable sampled every cycle around it
   task automatic ack_pulse(string tag, logic drv, logic [7:0] v);
      iack_n = 1'b0;
      exp_bus({tag, " fall+0"}, 1'b0, 8'h00); tick();
      exp_bus({tag, " fall+1"}, 1'b0, 8'h00); tick();
      exp_bus({tag, " fall+2"}, drv, drv ? v : 8'h00); tick();
      exp_bus({tag, " fall+3"}, drv, drv ? v : 8'h00);
      iack_n = 1'b1; tick();
      exp_bus({tag, " rise+1"}, drv, drv ? v : 8'h00); tick();
      exp_bus({tag, " rise+2"}, 1'b0, 8'h00); tick();
      tick();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : driver
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      exp_irq("R1 irq after reset", 1'b0);
      exp_bus("R1 bus after reset", 1'b0, 8'h00);
      peek("R1 status", 2'd3, 8'h00);
      peek("R1 control", 2'd0, 8'h00);
      peek("R1 vector", 2'd1, 8'h00);

      // R10 vector register
      host_write(2'd1, 8'hA5);
      peek("R10 vector readback", 2'd1, 8'hA5);

      // R2 DSP write raises request
      dsp_write(8'h3C);
      exp_irq("R2 irq after cmd", 1'b1);
      peek("R2 busy set", 2'd3, 8'h01);

      // R4 read of command returns word and clears
      host_rd = 1'b1;
      peek("R4 command data", 2'd2, 8'h3C);
      host_rd = 1'b0;
      exp_irq("R4 irq after read", 1'b0);
      peek("R4 busy cleared", 2'd3, 8'h00);

      // R3 mask keeps busy
      host_write(2'd0, 8'h01);
      dsp_write(8'h11);
      exp_irq("R3 irq masked", 1'b0);
      peek("R3 busy kept", 2'd3, 8'h01);
      host_write(2'd0, 8'h00);
      exp_irq("R3 irq after unmask", 1'b1);
      tick();

      // R5 clear bit
      host_write(2'd0, 8'h04);
      exp_irq("R5 irq after clear", 1'b0);
      peek("R5 busy cleared", 2'd3, 8'h00);
      peek("R5 clear bit reads 0", 2'd0, 8'h00);

      // R6 collisions
      dsp_cmd_wr = 1'b1; dsp_cmd_wdata = 8'h22;
      host_write(2'd0, 8'h04);
      dsp_cmd_wr = 1'b0;
      exp_irq("R6 write beats clear bit", 1'b1);
      peek("R6 busy after clear bit", 2'd3, 8'h01);
      dsp_cmd_wr = 1'b1; dsp_cmd_wdata = 8'h33;
      host_rd = 1'b1; host_addr = 2'd2;
      tick();
      dsp_cmd_wr = 1'b0; host_rd = 1'b0;
      exp_irq("R6 write beats command read", 1'b1);
      peek("R6 command updated", 2'd2, 8'h33);
      host_write(2'd0, 8'h04);

      // R7 single-pulse protocol
      ack_pulse("R7 single", 1'b1, 8'hA5);
      ack_pulse("R7 single again", 1'b1, 8'hA5);

      // R8 double-pulse protocol
      host_write(2'd0, 8'h02);
      peek("R8 mode bit", 2'd0, 8'h02);
      ack_pulse("R8 first pulse", 1'b0, 8'hA5);
      ack_pulse("R8 second pulse", 1'b1, 8'hA5);
      ack_pulse("R8 next first", 1'b0, 8'hA5);
      host_write(2'd1, 8'h5A);
      ack_pulse("R8 R10 new vector", 1'b1, 8'h5A);

      // R9 mode change resets the sequence
      ack_pulse("R9 arm", 1'b0, 8'h5A);
      host_write(2'd0, 8'h00);
      host_write(2'd0, 8'h02);
      ack_pulse("R9 first after toggle", 1'b0, 8'h5A);
      ack_pulse("R9 second after toggle", 1'b1, 8'h5A);
      exp_irq("R9 irq untouched by ack", 1'b0);
      tick();
      tick();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule